// File: doc/BRIEF.md
# Addressed Command Byte Decoder

This block sits on a shared broadcast byte stream and picks out the commands sent to its own node. Each byte is ASCII. A command starts with the node identifier. Four bytes follow: a waveform field, a frequency field, an output-control field and a closing end marker. When a complete, well-formed command has been collected, the block updates its registered waveform, frequency and output-enable settings, and it raises a one-cycle load strobe in the same cycle. It also publishes a compact mode code for those settings and an indicator that is high while the output is off.

Traffic for other nodes must never be taken for the block's own commands. When the block is listening and sees a foreign identifier, it drops a listening flag. It then ignores every byte, including any that happen to equal its own identifier, until an end marker arrives. The settings already in force stay untouched while a command is being received, so a downstream waveform generator keeps running without a glitch until the load strobe arrives.

The input is a valid/ready stream. The block never applies back-pressure: `in_ready` is high whenever reset is released, and a byte is consumed in every cycle where `in_valid` and `in_ready` are both high. A sender can therefore present bytes back to back, or with any number of idle cycles between them. Data presented while `in_valid` is low is ignored.

Top module: `cmd_byte_decoder`

## Requirements
- R1: After reset, `listening`=1, `cfg_load`=0, `wave_sel`=0, `freq_sel`=0, `out_en`=0, `mode_code`=0 and `idle_ind`=1.
- R2: `in_ready` is 1 whenever `rst_n` is 1. A byte is consumed only in a cycle with `in_valid`=1. Data present while `in_valid`=0 has no effect on any output.
- R3: While listening, the identifier byte 0x33 ('3') starts collection of a four-byte command, and `listening` stays 1.
- R4: While listening, any byte other than 0x33 or 0x38 clears `listening`. After that, every byte, 0x33 included, is ignored until 0x38 ('8') arrives. That 0x38 sets `listening` again and is not itself treated as an identifier.
- R5: A 0x38 received while listening is absorbed, and the block stays listening.
- R6: The command bytes after the identifier come in this order: waveform, frequency, output control, end marker. Waveform 0x31 gives `wave_sel`=0 (square) and 0x32 gives `wave_sel`=1 (sine). Frequency 0x31 gives `freq_sel`=0 (1 Hz) and 0x32 gives `freq_sel`=1 (10 Hz). Output 0x31 gives `out_en`=1 and 0x32 gives `out_en`=0.
- R7: For a valid command, the settings change and `cfg_load` is 1 in the cycle after the clock edge that consumes the end marker. `cfg_load` stays high for exactly one cycle.
- R8: If any of the three fields is not 0x31 or 0x32, or the fourth byte is not 0x38, the command is discarded. No load happens, the settings are kept, and the block goes back to listening.
- R9: While a command is being received, the settings, `mode_code` and `idle_ind` keep their values. They change only together with `cfg_load`.
- R10: `mode_code` is 0 when `out_en`=0, and otherwise 1 + 2*`wave_sel` + `freq_sel`. `idle_ind` is 1 exactly when `mode_code` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Block accepts a byte (high whenever reset is released) |
| in_data | input | 8 | ASCII byte from the broadcast stream |
| cfg_load | output | 1 | One-cycle strobe, high when new settings take effect |
| wave_sel | output | 1 | 0 square, 1 sine |
| freq_sel | output | 1 | 0 selects 1 Hz, 1 selects 10 Hz |
| out_en | output | 1 | Waveform output enabled |
| mode_code | output | 3 | 0 off, 1..4 the enabled waveform/frequency combination |
| idle_ind | output | 1 | High while `mode_code` is 0 |
| listening | output | 1 | Debug flag, low while foreign traffic is being skipped |

## Verification
The hardest situation to bring about is a muted decoder that receives its own identifier inside another node's payload. That byte has to be ignored, and only the end marker may re-arm the block. The bench reaches this state by sending a foreign identifier, followed by a payload that contains 0x33 and well-formed field characters, with 0x38 parked on the data bus during idle cycles. It then checks that `listening` stays low and that no load occurs. A sweep over every field character drawn from a valid/invalid set, combined with correct and wrong end markers, covers the paths that accept a command and the paths that discard it. Alternating gap lengths exercise both back-to-back and spaced bytes.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  typedef enum logic [2:0] {
    PS_LISTEN,
    PS_MUTE,
    PS_WAVE,
    PS_FREQ,
    PS_OUTC,
    PS_END
  } parse_st_e;

  typedef struct packed {
    logic wave;
    logic freq;
    logic en;
  } settings_t;
endpackage

// File: rtl/field_decode.sv
module field_decode #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CH_A = 8'h31,
  parameter logic [DATA_W-1:0] CH_B = 8'h32
) (
  input  logic [DATA_W-1:0] ch_i,
  output logic              ok_o,
  output logic              sel_o
);
  always_comb begin
    ok_o  = (ch_i == CH_A) || (ch_i == CH_B);
    sel_o = (ch_i == CH_B);
  end
endmodule

// File: rtl/cmd_parser.sv
module cmd_parser
  import cmd_dec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] NODE_ID  = 8'h33,
  parameter logic [DATA_W-1:0] END_MARK = 8'h38,
  parameter logic [DATA_W-1:0] CH_A     = 8'h31,
  parameter logic [DATA_W-1:0] CH_B     = 8'h32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_dat,
  output logic              commit_o,
  output settings_t         cmd_o,
  output logic              listening_o
);
  parse_st_e st_q, st_d;
  logic      wave_q, freq_q, en_q, bad_q;
  logic      fld_ok, fld_sel;
  logic      is_id, is_end;

  field_decode #(.DATA_W(DATA_W), .CH_A(CH_A), .CH_B(CH_B)) u_fld (
    .ch_i (byte_dat),
    .ok_o (fld_ok),
    .sel_o(fld_sel)
  );

  always_comb begin
    is_id  = (byte_dat == NODE_ID);
    is_end = (byte_dat == END_MARK);
    st_d   = st_q;
    if (byte_vld) begin
      unique case (st_q)
        PS_LISTEN: st_d = is_id ? PS_WAVE : (is_end ? PS_LISTEN : PS_MUTE);
        PS_MUTE:   st_d = is_end ? PS_LISTEN : PS_MUTE;
        PS_WAVE:   st_d = PS_FREQ;
        PS_FREQ:   st_d = PS_OUTC;
        PS_OUTC:   st_d = PS_END;
        PS_END:    st_d = PS_LISTEN;
        default:   st_d = PS_LISTEN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= PS_LISTEN;
      wave_q <= 1'b0;
      freq_q <= 1'b0;
      en_q   <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (byte_vld) begin
        unique case (st_q)
          PS_WAVE: begin
            wave_q <= fld_sel;
            bad_q  <= !fld_ok;
          end
          PS_FREQ: begin
            freq_q <= fld_sel;
            bad_q  <= bad_q | !fld_ok;
          end
          PS_OUTC: begin
            en_q  <= !fld_sel;
            bad_q <= bad_q | !fld_ok;
          end
          default: ;
        endcase
      end
    end
  end

  assign commit_o    = byte_vld && (st_q == PS_END) && is_end && !bad_q;
  assign cmd_o       = '{wave: wave_q, freq: freq_q, en: en_q};
  assign listening_o = (st_q != PS_MUTE);

  // R4
  mute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!listening_o && !(byte_vld && byte_dat == END_MARK)) |=> !listening_o);

  // R3
  id_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_LISTEN && byte_vld && byte_dat == NODE_ID) |=> (st_q == PS_WAVE && listening_o));

  // R5
  end_absorb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_LISTEN && byte_vld && byte_dat == END_MARK) |=> (st_q == PS_LISTEN));
endmodule

// File: rtl/settings_reg.sv
module settings_reg
  import cmd_dec_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  settings_t         cmd_i,
  output settings_t         cfg_o,
  output logic              load_o,
  output logic [CODE_W-1:0] code_o,
  output logic              idle_o
);
  logic [CODE_W-1:0] code_d;

  always_comb begin
    code_d = cmd_i.en ? (CODE_W'(1) + CODE_W'({cmd_i.wave, cmd_i.freq})) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_o  <= '0;
      load_o <= 1'b0;
      code_o <= '0;
      idle_o <= 1'b1;
    end else begin
      load_o <= commit_i;
      if (commit_i) begin
        cfg_o  <= cmd_i;
        code_o <= code_d;
        idle_o <= !cmd_i.en;
      end
    end
  end

  // R7
  load_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(cfg_o) && $stable(code_o) && $stable(idle_o)));

  // R10
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o == (code_o == '0));
endmodule

// File: rtl/cmd_byte_decoder.sv
module cmd_byte_decoder
  import cmd_dec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 3,
  parameter logic [DATA_W-1:0] NODE_ID  = 8'h33,
  parameter logic [DATA_W-1:0] END_MARK = 8'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              cfg_load,
  output logic              wave_sel,
  output logic              freq_sel,
  output logic              out_en,
  output logic [CODE_W-1:0] mode_code,
  output logic              idle_ind,
  output logic              listening
);
  localparam logic [DATA_W-1:0] CH_A = DATA_W'(8'h31);
  localparam logic [DATA_W-1:0] CH_B = DATA_W'(8'h32);

  logic      take;
  logic      commit;
  settings_t cmd, cfg;

  assign in_ready = rst_n;
  assign take     = in_valid && in_ready;

  cmd_parser #(
    .DATA_W(DATA_W), .NODE_ID(NODE_ID), .END_MARK(END_MARK), .CH_A(CH_A), .CH_B(CH_B)
  ) u_parse (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld   (take),
    .byte_dat   (in_data),
    .commit_o   (commit),
    .cmd_o      (cmd),
    .listening_o(listening)
  );

  settings_reg #(.CODE_W(CODE_W)) u_set (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit_i(commit),
    .cmd_i   (cmd),
    .cfg_o   (cfg),
    .load_o  (cfg_load),
    .code_o  (mode_code),
    .idle_o  (idle_ind)
  );

  assign wave_sel = cfg.wave;
  assign freq_sel = cfg.freq;
  assign out_en   = cfg.en;
endmodule

// File: tb/tb_cmd_byte_decoder.sv
module tb_cmd_byte_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, cfg_load, wave_sel, freq_sel, out_en, idle_ind, listening;
  logic [2:0] mode_code;

  int checks = 0;
  int errors = 0;
  logic [7:0] idle_dat = 8'h33;
  logic e_wave = 0, e_freq = 0, e_en = 0;

  always #10 clk = ~clk;

  cmd_byte_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cfg_load(cfg_load), .wave_sel(wave_sel), .freq_sel(freq_sel), .out_en(out_en),
    .mode_code(mode_code), .idle_ind(idle_ind), .listening(listening)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_settings(input string req);
    int code;
    code = e_en ? (1 + 2 * e_wave + e_freq) : 0;
    chk({req, " wave"}, wave_sel, e_wave);
    chk({req, " freq"}, freq_sel, e_freq);
    chk({req, " en"}, out_en, e_en);
    chk({req, " R10 code"}, mode_code, code);
    chk({req, " R10 idle"}, idle_ind, code == 0);
  endtask

  // called at a negedge; returns at a negedge after the consuming edge
  task automatic put(input logic [7:0] b, input int gap);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = idle_dat;
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] w, input logic [7:0] f, input logic [7:0] o,
                          input logic [7:0] e, input int gap);
    logic good;
    logic [7:0] body [4];
    body[0] = w; body[1] = f; body[2] = o; body[3] = e;
    good = (w == 8'h31 || w == 8'h32) && (f == 8'h31 || f == 8'h32) &&
           (o == 8'h31 || o == 8'h32) && (e == 8'h38);
    put(8'h33, gap);
    chk("R3 listening after id", listening, 1);
    for (int i = 0; i < 3; i++) begin
      put(body[i], gap);
      chk("R9 no load mid-command", cfg_load, 0);
      chk_settings("R9 hold");
    end
    put(body[3], 0);
    if (good) begin
      e_wave = (w == 8'h32);
      e_freq = (f == 8'h32);
      e_en   = (o == 8'h31);
    end
    chk(good ? "R7 load" : "R8 no load", cfg_load, good);
    chk_settings(good ? "R6 R7 settings" : "R8 kept");
    chk("R8 back to listening", listening, 1);
    @(negedge clk);
    chk("R7 one-cycle load", cfg_load, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R0 watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] fc [3];
    logic [7:0] ec [2];
    int n;
    fc[0] = 8'h31; fc[1] = 8'h32; fc[2] = 8'h30;
    ec[0] = 8'h38; ec[1] = 8'h39;

    repeat (3) @(negedge clk);
    chk("R1 load", cfg_load, 0);
    chk("R1 listening", listening, 1);
    chk_settings("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 ready", in_ready, 1);
    chk("R1 listening", listening, 1);
    chk_settings("R1 reset");

    // R2: idle data that would start a command is ignored
    idle_dat = 8'h33;
    repeat (3) @(negedge clk);
    put(8'h38, 0);
    chk("R5 stays listening", listening, 1);
    put(8'h38, 2);
    chk("R5 stays listening", listening, 1);
    send_cmd(8'h32, 8'h32, 8'h31, 8'h38, 0);
    chk("R2 idle 0x33 not an id", cfg_load, 0);

    // R4: foreign id, embedded own id, idle end-marker on bus
    put(8'h41, 0);
    chk("R4 muted by foreign id", listening, 0);
    idle_dat = 8'h38;
    put(8'h33, 1);
    chk("R4 own id ignored while muted", listening, 0);
    put(8'h31, 1);
    put(8'h31, 1);
    put(8'h32, 1);
    chk("R2 R4 still muted", listening, 0);
    chk("R4 no load", cfg_load, 0);
    chk_settings("R4 kept");
    put(8'h38, 0);
    chk("R4 end marker re-arms", listening, 1);
    idle_dat = 8'h33;
    put(8'h32, 0);
    chk("R4 foreign after re-arm", listening, 0);
    put(8'h38, 0);
    chk("R4 re-arm", listening, 1);

    // sweep of every field combination, good and bad end marker
    n = 0;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          for (int d = 0; d < 2; d++) begin
            send_cmd(fc[a], fc[b], fc[c], ec[d], n % 2);
            n++;
          end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule